// File: doc/BRIEF.md
# I2C Target Bus Event Monitor

This block sits beside an I2C target and watches the two bus wires together with the level the target itself puts on the data line. It recognises START, repeated START and STOP conditions, counts the clock pulses of every byte, and compares each address byte against a programmed 7-bit own address. It also detects the general-call address. When the target is transmitting, it decodes the acknowledge that the controller returns after each byte. It flags lost arbitration, and it flags conditions that arrive in the middle of a byte.

Each detected event sets a sticky bit in a 12-bit cause register. Software clears a bit by writing 1 to it. A maskable interrupt output is raised while any enabled cause is pending. On lost arbitration or a misplaced condition, the block emits a one-cycle abort pulse so that the target core can drop the transfer.

Top module: `i2c_tgt_evmon`

## Requirements
- R1: After reset the cause vector is all zero, and the interrupt and abort outputs are low.
- R2: Bit 5 is set on every START, where SDA falls while SCL is high. A repeated START sets it too.
- R3: The byte after a START is the address. It is sent MSB first: the 7-bit address is in bits 7:1 and R/W is in bit 0, where 1 means read. If bits 7:1 equal the own address, bit 6 is set. If the whole byte is 0x00, bit 7 is set. Any other address sets neither bit, and the block ignores the rest of that transfer.
- R4: A STOP or a repeated START that ends a transfer whose address matched the own address sets bit 4. This holds whatever value the address acknowledge had. If that address had R/W = 0, bit 3 is set as well. A transfer that did not match the own address sets neither bit, and a general call is such a transfer.
- R5: In a read addressed to this target, the acknowledge slot after each byte the target sends sets bit 2 when SDA is low and bit 1 when SDA is high. After a NACK the target stops sending. Acknowledges of the address or of received bytes set neither bit.
- R6: While the target sends the data bits of a byte and SCL is high, a difference between its drive level and the observed SDA sets bit 0. It also pulses abort, and no stop cause is raised for that transfer.
- R7: A START or STOP that arrives after the second SCL rise of a byte, and before its acknowledge rise, sets bit 8 and pulses abort. This applies only inside a tracked transfer. Such a condition raises no stop cause.
- R8: Writing 1 to a cause bit through the clear strobe clears that bit. If a new event for the same bit arrives in the same cycle, the bit stays set.
- R9: The interrupt output is high exactly when some cause bit and the matching mask bit are both 1.
- R10: Bits 11:9 of the cause vector always read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Observed bus clock line |
| sda_i | input | 1 | Observed bus data line |
| sda_drv_i | input | 1 | Level the target drives on SDA (1 = released) |
| own_addr_i | input | 7 | Own 7-bit target address |
| irq_mask_i | input | 12 | Interrupt enable for each cause bit |
| clr_wr_i | input | 1 | Write-1-to-clear strobe |
| clr_data_i | input | 12 | Bits to clear when the strobe is high |
| cause_o | output | 12 | Sticky event causes |
| irq_o | output | 1 | Masked interrupt request |
| abort_o | output | 1 | One-cycle abort request on arbitration loss or bus error |

## Verification
The bench drives bit-banged sequences and checks each one for the causes it should raise.

- A write to the own address followed by a repeated START to a foreign address shows that a stop cause belongs to the transfer that has just ended, not to the one that follows.
- An own-address write whose address is NACKed shows that a refused address still raises the stop causes.
- A read with one ACKed byte and one NACKed byte covers both acknowledge causes.
- A general call followed by a STOP tells general call apart from an own match.
- A forced low bit during a transmitted byte raises lost arbitration.
- Bursts cut short after three and after four bits raise bus errors, the second one suppressing the stop cause of a matched transfer.
- A clear strobe timed onto the START event cycle checks that the event wins.

// File: rtl/i2cmon_pkg.sv
package i2cmon_pkg;
  localparam int ADDR_W  = 7;
  localparam int BYTE_W  = ADDR_W + 1;
  localparam int CNT_W   = $clog2(BYTE_W + 1);
  localparam int CAUSE_W = 12;
  localparam int SYNC_N  = 2;

  // cause bit positions (software decodes these)
  localparam int C_ARB   = 0;
  localparam int C_NACK  = 1;
  localparam int C_ACK   = 2;
  localparam int C_WSTOP = 3;
  localparam int C_STOP  = 4;
  localparam int C_START = 5;
  localparam int C_AMTCH = 6;
  localparam int C_GCALL = 7;
  localparam int C_BERR  = 8;
  localparam logic [CAUSE_W-1:0] LIVE_MASK = CAUSE_W'((1 << (C_BERR + 1)) - 1);

  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] CNT_ACK  = CNT_W'(BYTE_W);

  typedef enum logic [2:0] {
    PH_IDLE, PH_ADDR, PH_RX, PH_TX, PH_HOLD, PH_SKIP
  } phase_t;

  function automatic logic own_hit(input logic [BYTE_W-1:0] b, input logic [ADDR_W-1:0] own);
    return b[BYTE_W-1:1] == own;
  endfunction

  function automatic logic gcall_hit(input logic [BYTE_W-1:0] b);
    return b == '0;
  endfunction

  // conditions are legal only before the second SCL rise of a byte
  function automatic logic in_err_window(input logic [CNT_W-1:0] c);
    return (c >= CNT_W'(2)) && (c <= CNT_ACK);
  endfunction

  function automatic logic is_tracked(input phase_t p);
    return (p == PH_ADDR) || (p == PH_RX) || (p == PH_TX) || (p == PH_HOLD);
  endfunction
endpackage

// File: rtl/i2cmon_sync.sv
module i2cmon_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain <= '1;
      else         chain <= {chain[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/i2cmon_cond.sv
module i2cmon_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_s_i,
  input  logic sda_s_i,
  output logic start_o,
  output logic stop_o,
  output logic rise_o
);
  logic scl_p, sda_p;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_s_i;
      sda_p <= sda_s_i;
    end
  end

  logic scl_steady_hi;
  assign scl_steady_hi = scl_s_i & scl_p;
  assign start_o = scl_steady_hi & sda_p & ~sda_s_i;
  assign stop_o  = scl_steady_hi & ~sda_p & sda_s_i;
  assign rise_o  = scl_s_i & ~scl_p;
endmodule

// File: rtl/i2cmon_proto.sv
module i2cmon_proto
  import i2cmon_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               stop_i,
  input  logic               rise_i,
  input  logic               scl_s_i,
  input  logic               sda_s_i,
  input  logic               drv_s_i,
  input  logic [ADDR_W-1:0]  own_i,
  output logic [CAUSE_W-1:0] set_o,
  output logic               abort_o
);
  phase_t             phase_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [BYTE_W-1:0]  shreg_q;
  logic               matched_q, gcall_q, rd_q;

  // named internal events
  logic              cond_ev, err_hit, arb_hit, addr_done, ack_slot, stop_qual;
  logic [BYTE_W-1:0] byte_in;
  phase_t            after_addr;

  assign cond_ev   = start_i | stop_i;
  assign err_hit   = cond_ev & is_tracked(phase_q) & in_err_window(cnt_q);
  assign arb_hit   = ~cond_ev & ~rise_i & (phase_q == PH_TX) & scl_s_i &
                     (cnt_q != '0) & (drv_s_i != sda_s_i);
  assign byte_in   = {shreg_q[BYTE_W-2:0], sda_s_i};
  assign addr_done = rise_i & (phase_q == PH_ADDR) & (cnt_q == CNT_LAST);
  assign ack_slot  = rise_i & is_tracked(phase_q) & (cnt_q == CNT_ACK);
  assign stop_qual = cond_ev & matched_q & ~err_hit;

  always_comb begin
    if (matched_q)    after_addr = rd_q ? PH_TX : PH_RX;
    else if (gcall_q) after_addr = PH_RX;
    else              after_addr = PH_SKIP;
  end

  always_comb begin
    set_o          = '0;
    set_o[C_START] = start_i;
    set_o[C_STOP]  = stop_qual;
    set_o[C_WSTOP] = stop_qual & ~rd_q;
    set_o[C_AMTCH] = addr_done & own_hit(byte_in, own_i);
    set_o[C_GCALL] = addr_done & gcall_hit(byte_in);
    set_o[C_ACK]   = ack_slot & (phase_q == PH_TX) & ~sda_s_i;
    set_o[C_NACK]  = ack_slot & (phase_q == PH_TX) & sda_s_i;
    set_o[C_ARB]   = arb_hit;
    set_o[C_BERR]  = err_hit;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q   <= PH_IDLE;
      cnt_q     <= '0;
      shreg_q   <= '0;
      matched_q <= 1'b0;
      gcall_q   <= 1'b0;
      rd_q      <= 1'b0;
      abort_o   <= 1'b0;
    end else begin
      abort_o <= arb_hit | err_hit;
      if (cond_ev) begin
        phase_q   <= start_i ? PH_ADDR : PH_IDLE;
        cnt_q     <= '0;
        matched_q <= 1'b0;
        gcall_q   <= 1'b0;
        rd_q      <= 1'b0;
      end else if (arb_hit) begin
        phase_q   <= PH_SKIP;
        matched_q <= 1'b0;
      end else if (rise_i && is_tracked(phase_q)) begin
        if (cnt_q == CNT_ACK) begin
          cnt_q <= '0;
          if (phase_q == PH_ADDR)     phase_q <= after_addr;
          else if (phase_q == PH_TX)  phase_q <= sda_s_i ? PH_HOLD : PH_TX;
        end else begin
          cnt_q   <= cnt_q + CNT_W'(1);
          shreg_q <= byte_in;
          if (addr_done) begin
            matched_q <= own_hit(byte_in, own_i);
            gcall_q   <= gcall_hit(byte_in);
            rd_q      <= byte_in[0];
          end
        end
      end
    end
  end

  assert_cnt_range_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_ACK);
  assert_match_kept_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_o[C_AMTCH] |=> matched_q);
  assert_nack_ends_tx_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_o[C_NACK] |=> (phase_q == PH_HOLD));
  assert_arb_abort_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arb_hit |=> (abort_o && phase_q == PH_SKIP && !matched_q));
  assert_berr_abort_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_hit |=> abort_o);
  assert_berr_nostop_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_o[C_BERR] |-> !set_o[C_STOP]);
endmodule

// File: rtl/i2cmon_cause.sv
module i2cmon_cause
  import i2cmon_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [CAUSE_W-1:0] set_i,
  input  logic               clr_wr_i,
  input  logic [CAUSE_W-1:0] clr_data_i,
  input  logic [CAUSE_W-1:0] mask_i,
  output logic [CAUSE_W-1:0] cause_o,
  output logic               irq_o
);
  logic [CAUSE_W-1:0] cause_q, clr_vec, cause_d;

  assign clr_vec = clr_wr_i ? clr_data_i : '0;
  assign cause_d = ((cause_q & ~clr_vec) | set_i) & LIVE_MASK;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cause_q <= '0;
    else         cause_q <= cause_d;
  end

  assign cause_o = cause_q;
  assign irq_o   = |(cause_q & mask_i);

  assert_event_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(set_i & LIVE_MASK)) |=> ((cause_q & $past(set_i & LIVE_MASK)) == $past(set_i & LIVE_MASK)));
  assert_w1c_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_wr_i |=> ((cause_q & $past(clr_data_i & ~set_i)) == '0));
endmodule

// File: rtl/i2c_tgt_evmon.sv
module i2c_tgt_evmon
  import i2cmon_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               scl_i,
  input  logic               sda_i,
  input  logic               sda_drv_i,
  input  logic [ADDR_W-1:0]  own_addr_i,
  input  logic [CAUSE_W-1:0] irq_mask_i,
  input  logic               clr_wr_i,
  input  logic [CAUSE_W-1:0] clr_data_i,
  output logic [CAUSE_W-1:0] cause_o,
  output logic               irq_o,
  output logic               abort_o
);
  logic [2:0]         synced;
  logic               scl_s, sda_s, drv_s;
  logic               start_ev, stop_ev, rise_ev;
  logic [CAUSE_W-1:0] set_vec;

  // drive level travels through the same stages so it lines up with the bus
  i2cmon_sync #(.W(3), .STAGES(SYNC_N)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sda_drv_i, sda_i, scl_i}),
    .q_o   (synced)
  );
  assign {drv_s, sda_s, scl_s} = synced;

  i2cmon_cond u_cond (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .scl_s_i(scl_s),
    .sda_s_i(sda_s),
    .start_o(start_ev),
    .stop_o (stop_ev),
    .rise_o (rise_ev)
  );

  i2cmon_proto u_proto (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_ev),
    .stop_i (stop_ev),
    .rise_i (rise_ev),
    .scl_s_i(scl_s),
    .sda_s_i(sda_s),
    .drv_s_i(drv_s),
    .own_i  (own_addr_i),
    .set_o  (set_vec),
    .abort_o(abort_o)
  );

  i2cmon_cause u_cause (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (set_vec),
    .clr_wr_i  (clr_wr_i),
    .clr_data_i(clr_data_i),
    .mask_i    (irq_mask_i),
    .cause_o   (cause_o),
    .irq_o     (irq_o)
  );

  assert_start_seen_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_ev |=> cause_o[C_START]);
  assert_abort_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> (cause_o[C_ARB] || cause_o[C_BERR] || $past(clr_wr_i)));
endmodule

// File: tb/tb_i2c_tgt_evmon.sv
module tb_i2c_tgt_evmon;
  localparam int H = 6;
  localparam int WATCHDOG = 150000;
  localparam logic [6:0] OWN = 7'h2A;
  // cause positions restated from the requirements
  localparam int B_ARB = 0, B_NACK = 1, B_ACK = 2, B_WST = 3, B_ST = 4,
                 B_SRT = 5, B_AM = 6, B_GC = 7, B_BE = 8;

  logic clk = 1'b0;
  always #2ns clk = ~clk;

  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, sda_t = 1'b1;
  logic sda_bus;
  assign sda_bus = sda_m & sda_t;
  logic [11:0] mask = '0;
  logic clr_wr = 1'b0;
  logic [11:0] clr_data = '0;
  logic [11:0] cause;
  logic irq, abort_p;

  int checks = 0, errors = 0, aborts = 0;
  logic [11:0] exp = '0;

  i2c_tgt_evmon dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_drv_i(sda_t), .own_addr_i(OWN), .irq_mask_i(mask),
    .clr_wr_i(clr_wr), .clr_data_i(clr_data),
    .cause_o(cause), .irq_o(irq), .abort_o(abort_p)
  );

  always @(negedge clk) if (rst_n && abort_p) aborts++;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] want);
    checks++;
    if (act !== want) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, want);
    end
  endtask

  task automatic hwait();
    repeat (H) @(negedge clk);
  endtask
  task automatic bus_start();
    sda_m = 1; scl_m = 1; hwait(); sda_m = 0; hwait(); scl_m = 0; hwait();
  endtask
  task automatic bus_rstart();
    sda_m = 1; sda_t = 1; hwait(); scl_m = 1; hwait(); sda_m = 0; hwait(); scl_m = 0; hwait();
  endtask
  task automatic bus_stop();
    sda_m = 0; sda_t = 1; hwait(); scl_m = 1; hwait(); sda_m = 1; hwait();
  endtask
  task automatic clk_bit(input logic m, input logic t);
    sda_m = m; sda_t = t; hwait(); scl_m = 1; hwait(); scl_m = 0; hwait();
  endtask
  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) clk_bit(b[i], 1'b1);
  endtask
  task automatic tgt_byte(input logic [7:0] b, input int force_at);
    for (int i = 7; i >= 0; i--) clk_bit((7 - i) == force_at ? 1'b0 : 1'b1, b[i]);
  endtask
  task automatic tgt_ack();
    clk_bit(1'b1, 1'b0);
  endtask
  task automatic w1c(input logic [11:0] v);
    @(negedge clk); clr_wr = 1; clr_data = v;
    @(negedge clk); clr_wr = 0; clr_data = '0;
    @(negedge clk);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int ab0;
    repeat (5) @(negedge clk);
    chk("R1 reset cause", cause, 0);
    chk("R1 reset irq", irq, 0);
    chk("R1 reset abort", abort_p, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // own-address write, then repeated START to a foreign address
    bus_start(); exp[B_SRT] = 1;
    chk("R2 start", cause, exp);
    send_byte({OWN, 1'b0}); exp[B_AM] = 1;
    chk("R3 own match", cause, exp);
    tgt_ack(); send_byte(8'hA5); tgt_ack();
    chk("R5 no ack cause on received data", cause, exp);
    bus_rstart(); exp[B_ST] = 1; exp[B_WST] = 1;
    chk("R4 restart ends matched write", cause, exp);
    w1c(12'h1FF); exp = '0;
    chk("R8 clear all", cause, exp);
    send_byte({7'h33, 1'b0}); clk_bit(1'b1, 1'b1);
    chk("R3 foreign address sets nothing", cause, exp);
    bus_stop();
    chk("R4 no stop cause for foreign address", cause, exp);

    // NACKed own address still yields stop causes
    bus_start(); send_byte({OWN, 1'b0}); clk_bit(1'b1, 1'b1); bus_stop();
    exp = '0; exp[B_SRT] = 1; exp[B_AM] = 1; exp[B_ST] = 1; exp[B_WST] = 1;
    chk("R4 nacked address stop", cause, exp);
    w1c(12'h1FF); exp = '0;

    // read with ACK then NACK
    bus_start(); send_byte({OWN, 1'b1}); tgt_ack();
    tgt_byte(8'h3C, -1); clk_bit(1'b0, 1'b1);
    exp[B_SRT] = 1; exp[B_AM] = 1; exp[B_ACK] = 1;
    chk("R5 ack received", cause, exp);
    tgt_byte(8'hC3, -1); clk_bit(1'b1, 1'b1); exp[B_NACK] = 1;
    chk("R5 nack received", cause, exp);
    bus_stop(); exp[B_ST] = 1;
    chk("R4 read stop no write-stop", cause, exp);

    // interrupt masking
    mask = 12'h010; @(negedge clk);
    chk("R9 irq enabled cause", irq, 1);
    mask = 12'h100; @(negedge clk);
    chk("R9 irq masked", irq, 0);
    mask = '0;
    w1c(12'h004); exp[B_ACK] = 0;
    chk("R8 clear single bit", cause, exp);
    w1c(12'hFFF); exp = '0;

    // general call
    bus_start(); send_byte(8'h00); tgt_ack(); send_byte(8'h12); tgt_ack(); bus_stop();
    exp[B_SRT] = 1; exp[B_GC] = 1;
    chk("R3 general call, R4 no stop", cause, exp);
    w1c(12'h1FF); exp = '0;

    // arbitration lost
    ab0 = aborts;
    bus_start(); send_byte({OWN, 1'b1}); tgt_ack();
    tgt_byte(8'hFF, 3); clk_bit(1'b1, 1'b1); bus_stop();
    exp[B_SRT] = 1; exp[B_AM] = 1; exp[B_ARB] = 1;
    chk("R6 arbitration lost", cause, exp);
    chk("R6 abort pulse", aborts - ab0, 1);
    w1c(12'h1FF); exp = '0;

    // bus error: STOP after three bits
    ab0 = aborts;
    bus_start(); clk_bit(1, 1); clk_bit(0, 1); clk_bit(1, 1); bus_stop();
    exp[B_SRT] = 1; exp[B_BE] = 1;
    chk("R7 stop mid byte", cause, exp);
    chk("R7 abort", aborts - ab0, 1);
    w1c(12'h1FF); exp = '0;

    // bus error on matched write suppresses stop cause
    ab0 = aborts;
    bus_start(); send_byte({OWN, 1'b0}); tgt_ack();
    clk_bit(1, 1); clk_bit(1, 1); clk_bit(0, 1); clk_bit(1, 1);
    bus_rstart(); bus_stop();
    exp[B_SRT] = 1; exp[B_AM] = 1; exp[B_BE] = 1;
    chk("R7 restart mid byte no stop cause", cause, exp);
    chk("R7 abort again", aborts - ab0, 1);
    w1c(12'h1FF); exp = '0;

    // event wins over clear in the same cycle
    @(negedge clk); sda_m = 0;
    @(negedge clk);
    @(negedge clk); clr_wr = 1; clr_data = 12'h020;
    @(negedge clk); clr_wr = 0; clr_data = '0;
    exp[B_SRT] = 1;
    chk("R8 event wins", cause, exp);
    hwait(); scl_m = 0; hwait();
    send_byte(8'h10); clk_bit(1, 1); bus_stop();
    chk("R3 foreign after collision", cause, exp);

    // reserved bits
    w1c(12'hE00);
    chk("R10 reserved zero", cause[11:9], 0);
    chk("R10 cause unchanged", cause, exp);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule